// File: doc/BRIEF.md
# Byte/Word Memory Access Unit

This unit connects a processor's load/store path to a data memory that is only 16 bits wide. Addresses from the processor are byte addresses in a 64 KB space. The unit turns each request into a word index for the memory. It then either moves a whole aligned 16-bit word or works on a single byte lane inside the word that holds the addressed byte.

Bytes are stored most-significant first. The even byte of each word is bits 15:8 and the odd byte is bits 7:0. A byte load returns the selected lane with zeros above it. A byte store is done as a read-modify-write over two memory cycles: the unit reads the containing word, replaces one lane, and writes the word back. A word access to an odd address is rejected with an error flag and leaves memory untouched. The memory is assumed to return read data in the same cycle as its address and to write on the clock edge when its write enable is high.

A requester raises `req_valid` for one cycle with the address, size, direction and data. It then waits for the single-cycle `rsp_ready` pulse before it issues the next request.

Top module: `lane_access_unit`

## Requirements
- R1: In the cycle a request is accepted, `mem_addr` equals byte address bits 15:1.
- R2: A word load from an even address returns the 16-bit memory word unchanged, with `rsp_ready` high one cycle after the request and `rsp_misalign` low.
- R3: A word load or store to an odd address produces `rsp_ready` and `rsp_misalign` one cycle later. `rsp_rdata` is zero, and no memory write takes place.
- R4: Lanes are big-endian. A word store of 0x1234 at address 1000 makes a byte load at 1000 return 0x0012 and a byte load at 1001 return 0x0034.
- R5: A byte load returns the selected byte in bits 7:0, with bits 15:8 forced to zero.
- R6: A byte store writes only bits 7:0 of `req_wdata` into the addressed lane. The other lane of the word keeps its value, and `rsp_ready` rises two cycles after the request.
- R7: An aligned word store writes `req_wdata` into the addressed word in the request cycle and answers one cycle later with `rsp_misalign` low and `rsp_rdata` zero.
- R8: During and after reset, with no request, `rsp_ready`, `rsp_misalign`, `rsp_rdata` and `mem_we` are all zero.
- R9: `rsp_ready` is a single-cycle pulse, and `rsp_rdata` returns to zero in the cycle after it.
- R10: A byte access never raises `rsp_misalign`, whether its address is even or odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Store data (bits 7:0 only for byte stores) |
| rsp_ready | output | 1 | Completion pulse |
| rsp_rdata | output | 16 | Load result, valid with `rsp_ready` |
| rsp_misalign | output | 1 | Odd-address word access rejected |
| mem_addr | output | 15 | Word index to memory |
| mem_wdata | output | 16 | Write data to memory |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Combinational read data from memory |

## Verification
The bench goes after lane order. A swapped mapping would return 0x0034 for the even byte of 0x1234, and byte stores would land in the wrong half. It stores into one lane and then reads the whole word back. A merge that forgot the old word would wipe the neighbouring byte, and a stuck write enable would clobber it. It also sends odd-address word stores followed by a word read. A unit that ignored the alignment rule would overwrite memory there or answer without the error flag. Response latency is counted for each access kind, so a byte store that answered after one cycle, or a pulse that stretched over two cycles, is caught.

// File: rtl/lau_pkg.sv
package lau_pkg;
   typedef enum logic [0:0] {
      S_IDLE = 1'b0,
      S_WB   = 1'b1
   } lau_state_e;
endpackage

// File: rtl/lau_lane.sv
module lau_lane #(
   parameter int DATA_W     = 16,
   parameter int LANE_W     = 8,
   parameter bit BIG_ENDIAN = 1'b1,
   localparam int NLANES    = DATA_W / LANE_W,
   localparam int SEL_W     = $clog2(NLANES)
) (
   input  logic [DATA_W-1:0] word_in,
   input  logic [SEL_W-1:0]  sel,
   input  logic [LANE_W-1:0] wlane,
   output logic [DATA_W-1:0] rd_ext,
   output logic [DATA_W-1:0] merged
);
   logic [SEL_W-1:0] phys;

   generate
      if (BIG_ENDIAN) begin : g_be
         assign phys = SEL_W'(NLANES - 1) - sel;
      end else begin : g_le
         assign phys = sel;
      end
   endgenerate

   generate
      for (genvar g = 0; g < NLANES; g++) begin : g_lane
         assign merged[g*LANE_W +: LANE_W] =
            (phys == SEL_W'(g)) ? wlane : word_in[g*LANE_W +: LANE_W];
      end
   endgenerate

   always_comb begin
      rd_ext = '0;
      for (int i = 0; i < NLANES; i++) begin
         if (phys == SEL_W'(i)) rd_ext[LANE_W-1:0] = word_in[i*LANE_W +: LANE_W];
      end
   end
endmodule

// File: rtl/lau_ctrl.sv
module lau_ctrl
   import lau_pkg::*;
#(
   parameter int SEL_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             req_byte,
   input  logic [SEL_W-1:0] req_lo,
   output logic             in_wb,
   output logic             mem_we,
   output logic             cap_rmw,
   output logic             rd_word,
   output logic             rd_byte,
   output logic             rsp_ready,
   output logic             rsp_misalign
);
   lau_state_e state, state_nx;
   logic accept, misal;

   assign accept  = (state == S_IDLE) && req_valid;
   assign misal   = !req_byte && (req_lo != '0);
   assign in_wb   = (state == S_WB);
   assign cap_rmw = accept && req_write && req_byte;
   assign rd_word = accept && !req_write && !req_byte && !misal;
   assign rd_byte = accept && !req_write && req_byte;
   assign mem_we  = in_wb || (accept && req_write && !req_byte && !misal);

   always_comb begin
      state_nx = state;
      case (state)
         S_IDLE:  if (cap_rmw) state_nx = S_WB;
         S_WB:    state_nx = S_IDLE;
         default: state_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= S_IDLE;
         rsp_ready    <= 1'b0;
         rsp_misalign <= 1'b0;
      end else begin
         state        <= state_nx;
         rsp_ready    <= (accept && !cap_rmw) || in_wb;
         rsp_misalign <= accept && misal;
      end
   end

   // R3: a rejected word access never reaches memory
   a_r3_no_write_misalign: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && req_valid && !req_byte && req_lo != '0) |-> !mem_we);
   // R3: the error flag only accompanies a completion
   a_r3_flag_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_misalign |-> rsp_ready);
   // R6: the write-back cycle is followed by completion
   a_r6_wb_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_WB) |=> (rsp_ready && state == S_IDLE));
endmodule

// File: rtl/lane_access_unit.sv
module lane_access_unit
   import lau_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter int LANE_W     = 8,
   parameter bit BIG_ENDIAN = 1'b1,
   localparam int NLANES    = DATA_W / LANE_W,
   localparam int SEL_W     = $clog2(NLANES),
   localparam int WIDX_W    = ADDR_W - SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_byte,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_ready,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_misalign,
   output logic [WIDX_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] mem_rdata
);
   generate
      if (NLANES < 2 || NLANES * LANE_W != DATA_W) begin : g_bad_lanes
         $error("DATA_W must be a multiple (>=2) of LANE_W");
      end
      if (ADDR_W <= SEL_W) begin : g_bad_addr
         $error("ADDR_W too small for lane select");
      end
   endgenerate

   logic              in_wb, cap_rmw, rd_word, rd_byte;
   logic [WIDX_W-1:0] widx_q;
   logic [DATA_W-1:0] merged, merged_q, rd_ext, rdata_q;

   lau_ctrl #(.SEL_W(SEL_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_write    (req_write),
      .req_byte     (req_byte),
      .req_lo       (req_addr[SEL_W-1:0]),
      .in_wb        (in_wb),
      .mem_we       (mem_we),
      .cap_rmw      (cap_rmw),
      .rd_word      (rd_word),
      .rd_byte      (rd_byte),
      .rsp_ready    (rsp_ready),
      .rsp_misalign (rsp_misalign)
   );

   lau_lane #(.DATA_W(DATA_W), .LANE_W(LANE_W), .BIG_ENDIAN(BIG_ENDIAN)) u_lane (
      .word_in (mem_rdata),
      .sel     (req_addr[SEL_W-1:0]),
      .wlane   (req_wdata[LANE_W-1:0]),
      .rd_ext  (rd_ext),
      .merged  (merged)
   );

   assign mem_addr  = in_wb ? widx_q   : req_addr[ADDR_W-1:SEL_W];
   assign mem_wdata = in_wb ? merged_q : req_wdata;
   assign rsp_rdata = rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         widx_q   <= '0;
         merged_q <= '0;
         rdata_q  <= '0;
      end else begin
         if (cap_rmw) begin
            widx_q   <= req_addr[ADDR_W-1:SEL_W];
            merged_q <= merged;
         end
         rdata_q <= rd_word ? mem_rdata : (rd_byte ? rd_ext : '0);
      end
   end

   // R6: write-back targets the word that was read
   a_r6_rmw_same_word: assert property (@(posedge clk) disable iff (!rst_n)
      in_wb |-> (mem_we && mem_addr == $past(mem_addr)));
   // R5: byte loads come back zero-extended
   a_r5_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      rd_byte |=> (rsp_rdata[DATA_W-1:LANE_W] == '0 && rsp_ready));
endmodule

// File: tb/sim_lane_access_unit.sv
`timescale 1ns/1ps
module sim_lane_access_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
   logic [15:0] req_addr = '0, req_wdata = '0;
   logic        rsp_ready, rsp_misalign, mem_we;
   logic [15:0] rsp_rdata, mem_wdata, mem_rdata;
   logic [14:0] mem_addr;
   logic [15:0] mem [0:1023];
   int          errors = 0, checks = 0;

   always #4 clk = ~clk;

   always_ff @(posedge clk) if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
   assign mem_rdata = mem[mem_addr[9:0]];

   lane_access_unit u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_misalign(rsp_misalign),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
   );

   // {req(4), wr, byte, addr(16), wdata(16), exp_rdata(16), exp_mis, exp_cycles(2)}
   localparam int NV = 16;
   localparam logic [56:0] VEC [NV] = '{
      {4'd7, 1'b1, 1'b0, 16'd1000, 16'h1234, 16'h0000, 1'b0, 2'd1}, // R7
      {4'd2, 1'b0, 1'b0, 16'd1000, 16'h0000, 16'h1234, 1'b0, 2'd1}, // R2
      {4'd4, 1'b0, 1'b1, 16'd1000, 16'h0000, 16'h0012, 1'b0, 2'd1}, // R4 even lane
      {4'd4, 1'b0, 1'b1, 16'd1001, 16'h0000, 16'h0034, 1'b0, 2'd1}, // R4 odd lane
      {4'd6, 1'b1, 1'b1, 16'd1001, 16'h00AB, 16'h0000, 1'b0, 2'd2}, // R6
      {4'd6, 1'b0, 1'b0, 16'd1000, 16'h0000, 16'h12AB, 1'b0, 2'd1}, // R6 other lane kept
      {4'd6, 1'b1, 1'b1, 16'd1000, 16'hFFCD, 16'h0000, 1'b0, 2'd2}, // R6 upper wdata unused
      {4'd6, 1'b0, 1'b0, 16'd1000, 16'h0000, 16'hCDAB, 1'b0, 2'd1}, // R6
      {4'd3, 1'b1, 1'b0, 16'd1001, 16'hDEAD, 16'h0000, 1'b1, 2'd1}, // R3 store rejected
      {4'd3, 1'b0, 1'b0, 16'd1000, 16'h0000, 16'hCDAB, 1'b0, 2'd1}, // R3 memory untouched
      {4'd3, 1'b0, 1'b0, 16'd1001, 16'h0000, 16'h0000, 1'b1, 2'd1}, // R3 load rejected
      {4'd7, 1'b1, 1'b0, 16'd2,    16'hBEEF, 16'h0000, 1'b0, 2'd1}, // R7
      {4'd10,1'b0, 1'b1, 16'd3,    16'h0000, 16'h00EF, 1'b0, 2'd1}, // R10 odd byte
      {4'd5, 1'b0, 1'b1, 16'd2,    16'h0000, 16'h00BE, 1'b0, 2'd1}, // R5 zero-extend
      {4'd10,1'b1, 1'b1, 16'd3,    16'h0011, 16'h0000, 1'b0, 2'd2}, // R10 odd byte store
      {4'd6, 1'b0, 1'b0, 16'd2,    16'h0000, 16'hBE11, 1'b0, 2'd1}  // R6
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic access(input bit wr, input bit bt, input logic [15:0] a, input logic [15:0] wd,
                         output logic [15:0] rd, output logic mis, output int cyc,
                         output logic [14:0] widx);
      req_valid = 1'b1; req_write = wr; req_byte = bt; req_addr = a; req_wdata = wd;
      #1 widx = mem_addr;
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      cyc = 1;
      while (!rsp_ready && cyc < 8) begin
         @(posedge clk); @(negedge clk);
         cyc++;
      end
      rd = rsp_rdata; mis = rsp_misalign;
   endtask

   initial begin
      #(8 * 50000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:0] rd;
      logic        mis;
      int          cyc;
      logic [14:0] widx;
      repeat (3) @(negedge clk);
      // R8 during reset
      check(!rsp_ready && !rsp_misalign && rsp_rdata == 0 && !mem_we, "R8 in reset",
            {rsp_ready, rsp_misalign, mem_we}, 0);
      rst_n = 1'b1;
      @(negedge clk); @(negedge clk);
      check(!rsp_ready && !rsp_misalign && rsp_rdata == 0 && !mem_we, "R8 after reset",
            {rsp_ready, rsp_misalign, mem_we, rsp_rdata}, 0);

      for (int i = 0; i < NV; i++) begin
         access(VEC[i][52], VEC[i][51], VEC[i][50:35], VEC[i][34:19], rd, mis, cyc, widx);
         check(widx == VEC[i][50:36], $sformatf("R1 vec %0d", i), widx, VEC[i][50:36]);
         check(rd == VEC[i][18:3], $sformatf("R%0d vec %0d rdata", VEC[i][56:53], i), rd, VEC[i][18:3]);
         check(mis == VEC[i][2], $sformatf("R%0d vec %0d misalign", VEC[i][56:53], i), mis, VEC[i][2]);
         check(cyc == int'(VEC[i][1:0]), $sformatf("R%0d vec %0d latency", VEC[i][56:53], i), cyc, VEC[i][1:0]);
      end

      // R9: pulse lasts one cycle, data clears afterwards
      access(1'b0, 1'b0, 16'd1000, 16'h0, rd, mis, cyc, widx);
      @(posedge clk); @(negedge clk);
      check(!rsp_ready && rsp_rdata == 0, "R9 pulse width", {rsp_ready, rsp_rdata}, 0);

      // R1: top of the address space
      access(1'b0, 1'b1, 16'hFFFF, 16'h0, rd, mis, cyc, widx);
      check(widx == 15'h7FFF, "R1 top address", widx, 15'h7FFF);
      check(mis == 1'b0 && rd[15:8] == 8'h00, "R10 odd byte high address", {mis, rd[15:8]}, 0);

      // R8: idle bus keeps write enable low
      @(negedge clk);
      check(!mem_we && !rsp_ready, "R8 idle", {mem_we, rsp_ready}, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule